// File: doc/BRIEF.md
# Paired-Byte Word Move Sequencer

This block runs the two word-move instructions that treat the accumulator (A) and the Y register as one 16-bit value, with Y as the upper byte and A as the lower byte. When it accepts a start request it fetches a one-byte direct-page offset through the program address. It then either loads two neighbouring direct-page bytes into the pair or stores the pair into two neighbouring direct-page bytes. The memory bus allows one access per cycle. Read data comes back registered, on the cycle after the read request.

A load ends by presenting the new A and Y values, a one-cycle `ld_valid` pulse and new N and Z flags. N and Z are computed over the whole 16-bit pair. A store first performs one discarded read of the low address and then writes the two bytes on consecutive cycles. A store leaves the flags unchanged. The direct page is selected by an upper address byte supplied with the request. The second byte's offset wraps within that page.

Top module: `ya_word_mover`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `ld_valid`, `flag_n`, `flag_z`, `acc_out` and `y_out` are all zero.
- R2: Load (opcode 0xBA) accepted at edge E. The bus reads `pc_addr` in cycle 1 and `{dp_hi, d}` in cycle 2, where d is the byte returned. Cycle 3 makes no request. Cycle 4 reads `{dp_hi, d+1}`.
- R3: After a load, `acc_out` holds the byte read from `{dp_hi,d}` and `y_out` holds the byte read from `{dp_hi,d+1}`. `ld_valid` is high for exactly one cycle, cycle 6.
- R4: After a load, `flag_n` equals bit 15 of the pair, which is bit 7 of `y_out`.
- R5: After a load, `flag_z` is 1 only when all 16 bits of the pair are zero. A zero in only one of the two bytes gives 0.
- R6: Store (opcode 0xDA) accepted at edge E. The bus reads `pc_addr` in cycle 1 and makes a discarded read of `{dp_hi,d}` in cycle 2. It writes `acc_in` (sampled at E) to `{dp_hi,d}` in cycle 3. It writes `y_in` (sampled at E) to `{dp_hi,d+1}` in cycle 4.
- R7: A store leaves `flag_n`, `flag_z`, `acc_out` and `y_out` unchanged and raises no `ld_valid`.
- R8: When d is 0xFF, the second byte is at offset 0x00 in the same page `dp_hi`.
- R9: `busy` is high in cycles 1 to 4, which run through the final access, and low from cycle 5.
- R10: A start is ignored while `busy` is high, and a start carrying any opcode other than 0xBA or 0xDA is ignored. An ignored start causes no bus request and leaves the running sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin an instruction |
| opcode | input | 8 | Instruction code sampled with start |
| pc_addr | input | 16 | Address of the offset byte |
| dp_hi | input | 8 | Upper address byte of the direct page |
| acc_in | input | 8 | A value to store |
| y_in | input | 8 | Y value to store |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Bus access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after the read |
| acc_out | output | 8 | Loaded A |
| y_out | output | 8 | Loaded Y |
| ld_valid | output | 1 | One-cycle pulse when a load result is new |
| flag_n | output | 1 | Negative flag of the last load |
| flag_z | output | 1 | Zero flag of the last load |

## Verification
Cycle 1 is the cycle after the edge that accepts `start`. Bus outputs are due in cycles 1 to 4 and `busy` falls in cycle 5. The load results and `ld_valid` appear in cycle 6, because the upper byte arrives registered in cycle 5. The bench drives at a falling edge and then samples once at every later falling edge. Each sample is compared against an expected value that the bench derives from the cycle number, the opcode and the chosen offset. The memory model answers reads one edge later and places distinct bytes at the operand and both data addresses. A wrong address or an off-by-one cycle therefore shows up as a wrong value.

// File: rtl/ywm_pkg.sv
// Shared definitions for the word-move sequencer.
// Assumes: one bus access per cycle, read data registered one cycle later.
package ywm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LD_LO,
        S_LD_GAP,
        S_LD_HI,
        S_ST_DUMMY,
        S_ST_WLO,
        S_ST_WHI
    } seq_state_t;
endpackage

// File: rtl/ywm_ctrl.sv
// Sequence controller: accepts a start with a supported opcode while idle
// and steps through the load or store cycle plan.
// Assumes: start is ignored outside S_IDLE.
module ywm_ctrl #(
    parameter int OPW = 8,
    parameter logic [OPW-1:0] OP_LOAD  = 8'hBA,
    parameter logic [OPW-1:0] OP_STORE = 8'hDA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [OPW-1:0]      opcode,
    output ywm_pkg::seq_state_t state,
    output logic                accept
);
    import ywm_pkg::*;

    logic       is_store;
    seq_state_t nxt;

    // Accept only supported opcodes and only while idle.
    always_comb accept = start && (state == S_IDLE)
                         && ((opcode == OP_LOAD) || (opcode == OP_STORE));

    // Next-state plan for both instructions.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:     if (accept) nxt = S_FETCH;
            S_FETCH:    nxt = is_store ? S_ST_DUMMY : S_LD_LO;
            S_LD_LO:    nxt = S_LD_GAP;
            S_LD_GAP:   nxt = S_LD_HI;
            S_LD_HI:    nxt = S_IDLE;
            S_ST_DUMMY: nxt = S_ST_WLO;
            S_ST_WLO:   nxt = S_ST_WHI;
            S_ST_WHI:   nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // State and instruction-kind registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            is_store <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) is_store <= (opcode == OP_STORE);
        end
    end
endmodule

// File: rtl/ywm_addr.sv
// Bus driver: latches request operands, captures the direct-page offset
// and forms address, strobe and write data for each state.
// Assumes: mem_rdata carries the fetched offset in S_LD_LO / S_ST_DUMMY.
module ywm_addr #(
    parameter int AW = 16,
    parameter int DW = 8,
    localparam int PW = AW - DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ywm_pkg::seq_state_t state,
    input  logic                accept,
    input  logic [AW-1:0]       pc_addr,
    input  logic [PW-1:0]       dp_hi,
    input  logic [DW-1:0]       acc_in,
    input  logic [DW-1:0]       y_in,
    input  logic [DW-1:0]       mem_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata
);
    import ywm_pkg::*;

    logic [AW-1:0] pc_q;
    logic [PW-1:0] page_q;
    logic [DW-1:0] a_q, y_q, dp_q, dp_inc;

    // Offset of the second byte wraps inside the page.
    always_comb dp_inc = dp_q + {{(DW-1){1'b0}}, 1'b1};

    // Latch request operands at accept, offset when it arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            page_q <= '0;
            a_q    <= '0;
            y_q    <= '0;
            dp_q   <= '0;
        end else begin
            if (accept) begin
                pc_q   <= pc_addr;
                page_q <= dp_hi;
                a_q    <= acc_in;
                y_q    <= y_in;
            end
            if (state == S_LD_LO || state == S_ST_DUMMY) dp_q <= mem_rdata;
        end
    end

    // Per-state bus request.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = pc_q;
            end
            S_LD_LO, S_ST_DUMMY: begin
                mem_req  = 1'b1;
                mem_addr = {page_q, mem_rdata};
            end
            S_LD_HI: begin
                mem_req  = 1'b1;
                mem_addr = {page_q, dp_inc};
            end
            S_ST_WLO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {page_q, dp_q};
                mem_wdata = a_q;
            end
            S_ST_WHI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {page_q, dp_inc};
                mem_wdata = y_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ywm_result.sv
// Result unit: collects the two loaded bytes and computes N and Z over the
// 16-bit pair; outputs hold until the next load completes.
// Assumes: the upper byte is on mem_rdata the cycle after S_LD_HI.
module ywm_result #(
    parameter int DW = 8,
    localparam int WW = 2 * DW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ywm_pkg::seq_state_t state,
    input  logic [DW-1:0]       mem_rdata,
    output logic [DW-1:0]       acc_out,
    output logic [DW-1:0]       y_out,
    output logic                ld_valid,
    output logic                flag_n,
    output logic                flag_z
);
    import ywm_pkg::*;

    logic [DW-1:0] lo_q;
    logic          hi_pend;
    logic [WW-1:0] pair;

    always_comb pair = {mem_rdata, lo_q};

    // Capture low byte, then commit the pair when the upper byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_pend  <= 1'b0;
            acc_out  <= '0;
            y_out    <= '0;
            ld_valid <= 1'b0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
        end else begin
            if (state == S_LD_GAP) lo_q <= mem_rdata;
            hi_pend  <= (state == S_LD_HI);
            ld_valid <= hi_pend;
            if (hi_pend) begin
                acc_out <= lo_q;
                y_out   <= mem_rdata;
                flag_n  <= pair[WW-1];
                flag_z  <= (pair == '0);
            end
        end
    end
endmodule

// File: rtl/ya_word_mover.sv
// Top of the word-move sequencer: controller, bus driver and result unit.
// Assumes: a registered single-port bus and the opcodes set by parameters.
module ya_word_mover #(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int OPW = 8,
    parameter logic [OPW-1:0] OP_LOAD  = 8'hBA,
    parameter logic [OPW-1:0] OP_STORE = 8'hDA,
    localparam int PW = AW - DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] opcode,
    input  logic [AW-1:0]  pc_addr,
    input  logic [PW-1:0]  dp_hi,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  y_in,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [DW-1:0]  acc_out,
    output logic [DW-1:0]  y_out,
    output logic           ld_valid,
    output logic           flag_n,
    output logic           flag_z
);
    import ywm_pkg::*;

    seq_state_t state;
    logic       accept;

    // Busy covers every non-idle state, through the last access.
    always_comb busy = (state != S_IDLE);

    ywm_ctrl #(.OPW(OPW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .state(state), .accept(accept)
    );

    ywm_addr #(.AW(AW), .DW(DW)) u_addr (
        .clk(clk), .rst_n(rst_n), .state(state), .accept(accept),
        .pc_addr(pc_addr), .dp_hi(dp_hi), .acc_in(acc_in), .y_in(y_in),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    ywm_result #(.DW(DW)) u_result (
        .clk(clk), .rst_n(rst_n), .state(state), .mem_rdata(mem_rdata),
        .acc_out(acc_out), .y_out(y_out), .ld_valid(ld_valid),
        .flag_n(flag_n), .flag_z(flag_z)
    );
endmodule

// File: rtl/ywm_checker.sv
// Property checker for ya_word_mover, attached by bind below.
// Assumes: ports observed as seen at the rising clock edge.
module ywm_checker #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          ld_valid,
    input logic          flag_n,
    input logic          flag_z,
    input logic [DW-1:0] acc_out,
    input logic [DW-1:0] y_out
);
    // R9 / R10: bus activity only inside a busy sequence
    a_r9_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R3: the result strobe lasts a single cycle
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid);

    // R4: negative flag follows the top bit of the pair
    a_r4_n_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (flag_n == y_out[DW-1]));

    // R5: zero flag covers both bytes
    a_r5_z_both_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (flag_z == ((acc_out == '0) && (y_out == '0))));

    // R7: flags do not move across a store write
    a_r7_store_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> ($stable(flag_n) && $stable(flag_z)));

    // R6 / R8: first write is followed by a write to the next offset, same page
    a_r6_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !$past(mem_req && mem_we)) |=>
        (mem_req && mem_we
         && (mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW]))
         && (mem_addr[DW-1:0] == DW'($past(mem_addr[DW-1:0]) + 1'b1))));
endmodule

bind ya_word_mover ywm_checker #(.AW(AW), .DW(DW)) u_ywm_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .ld_valid(ld_valid),
    .flag_n(flag_n), .flag_z(flag_z), .acc_out(acc_out), .y_out(y_out)
);

// File: tb/ya_word_mover_bench.sv
module ya_word_mover_bench;
    localparam logic [7:0] PAGE = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] pc_addr = '0;
    logic [7:0]  dp_hi = PAGE;
    logic [7:0]  acc_in = '0, y_in = '0;
    logic        busy, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  acc_out, y_out;
    logic        ld_valid, flag_n, flag_z;

    int n_chk = 0, n_fail = 0;
    logic [15:0] cur_pc = '0;
    logic [7:0]  cur_dp = '0, cur_lo = '0, cur_hi = '0;
    logic        exp_n = 1'b0, exp_z = 1'b0;
    logic [7:0]  exp_a = '0, exp_y = '0;

    always #10 clk = ~clk;

    ya_word_mover u_ya_word_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .pc_addr(pc_addr), .dp_hi(dp_hi), .acc_in(acc_in), .y_in(y_in),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .acc_out(acc_out),
        .y_out(y_out), .ld_valid(ld_valid), .flag_n(flag_n), .flag_z(flag_z)
    );

    // Registered memory model: operand at the program address, data bytes at
    // the chosen offset and the wrapped next offset, filler elsewhere.
    always @(posedge clk) begin
        if (mem_req && !mem_we) begin
            if (mem_addr == cur_pc)                                mem_rdata <= cur_dp;
            else if (mem_addr == {PAGE, cur_dp})                   mem_rdata <= cur_lo;
            else if (mem_addr == {PAGE, 8'(cur_dp + 8'd1)})        mem_rdata <= cur_hi;
            else                                                   mem_rdata <= 8'hEE;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Run one instruction; optionally inject a second start while busy (R10).
    task automatic run_op(input logic [7:0] op, input logic [7:0] dp,
                          input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] a, input logic [7:0] y,
                          input logic [15:0] pc, input bit poke);
        bit is_ld;
        logic [15:0] a0, a1;
        is_ld  = (op == 8'hBA);
        cur_pc = pc; cur_dp = dp; cur_lo = lo; cur_hi = hi;
        a0 = {PAGE, dp};
        a1 = {PAGE, 8'(dp + 8'd1)};
        @(negedge clk);
        start = 1'b1; opcode = op; pc_addr = pc; acc_in = a; y_in = y;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            chk($sformatf("R9 busy cycle %0d", c), 16'(busy), 16'(c <= 4));
            case (c)
                1: begin
                    chk("R2/R6 fetch req", 16'(mem_req), 16'd1);
                    chk("R2/R6 fetch addr", mem_addr, pc);
                end
                2: begin
                    chk("R2/R6 first dp read", {14'd0, mem_req, mem_we}, 16'd2);
                    chk("R2/R6 first dp addr", mem_addr, a0);
                end
                3: if (is_ld) chk("R2 idle cycle no req", 16'(mem_req), 16'd0);
                   else begin
                       chk("R6 write A strobe", {14'd0, mem_req, mem_we}, 16'd3);
                       chk("R6 write A addr", mem_addr, a0);
                       chk("R6 write A data", 16'(mem_wdata), 16'(a));
                   end
                4: if (is_ld) begin
                       chk("R2 second read", {14'd0, mem_req, mem_we}, 16'd2);
                       chk("R2/R8 second read addr", mem_addr, a1);
                   end else begin
                       chk("R6 write Y strobe", {14'd0, mem_req, mem_we}, 16'd3);
                       chk("R6/R8 write Y addr", mem_addr, a1);
                       chk("R6 write Y data", 16'(mem_wdata), 16'(y));
                   end
                default: chk("R9 no req after final access", 16'(mem_req), 16'd0);
            endcase
            if (c == 1) start = 1'b0;
            if (c == 2 && poke) begin start = 1'b1; opcode = 8'hDA; end
            if (c == 3) start = 1'b0;
        end
        if (is_ld) begin
            exp_a = lo; exp_y = hi;
            exp_n = hi[7];
            exp_z = (lo == 8'd0) && (hi == 8'd0);
        end
        @(negedge clk);
        chk("R3/R7 ld_valid", 16'(ld_valid), 16'(is_ld));
        chk("R3/R7 acc_out", 16'(acc_out), 16'(exp_a));
        chk("R3/R7 y_out", 16'(y_out), 16'(exp_y));
        chk("R4/R7 flag_n", 16'(flag_n), 16'(exp_n));
        chk("R5/R7 flag_z", 16'(flag_z), 16'(exp_z));
        @(negedge clk);
        chk("R3 ld_valid single cycle", 16'(ld_valid), 16'd0);
    endtask

    // {opcode, offset, low byte, high byte, A to store, Y to store}
    localparam logic [47:0] VEC [0:7] = '{
        {8'hBA, 8'h10, 8'h34, 8'h12, 8'h00, 8'h00},
        {8'hBA, 8'h20, 8'h00, 8'h80, 8'h00, 8'h00},
        {8'hBA, 8'h30, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'hDA, 8'h50, 8'h99, 8'h99, 8'hAB, 8'hCD},
        {8'hBA, 8'h40, 8'h55, 8'h00, 8'h00, 8'h00},
        {8'hBA, 8'hFF, 8'h01, 8'hFE, 8'h00, 8'h00},
        {8'hDA, 8'hFF, 8'h00, 8'h00, 8'h11, 8'h22},
        {8'hDA, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk("R1 busy", 16'(busy), 16'd0);
        chk("R1 mem_req", 16'(mem_req), 16'd0);
        chk("R1 ld_valid", 16'(ld_valid), 16'd0);
        chk("R1 flags", {14'd0, flag_n, flag_z}, 16'd0);
        chk("R1 pair", {y_out, acc_out}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++)
            run_op(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16],
                   VEC[i][15:8], VEC[i][7:0], 16'h0040 + 16'(i), 1'b0);

        // R10: unsupported opcode causes no activity
        @(negedge clk);
        start = 1'b1; opcode = 8'hE4; pc_addr = 16'h0060;
        for (int c = 1; c <= 5; c++) begin
            @(negedge clk);
            start = 1'b0;
            chk("R10 bad opcode no req", 16'(mem_req), 16'd0);
            chk("R10 bad opcode not busy", 16'(busy), 16'd0);
        end
        chk("R10 bad opcode flags held", {14'd0, flag_n, flag_z}, {14'd0, exp_n, exp_z});

        // R10: store request during a running load is ignored
        run_op(8'hBA, 8'h77, 8'h00, 8'h01, 8'h00, 8'h00, 16'h0070, 1'b1);
        chk("R10 no late sequence", 16'(busy), 16'd0);

        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end
endmodule